// File: doc/BRIEF.md
# Private Interrupt Configuration Bank

This block holds the per-processor state of 32 private interrupts. Interrupts 0 to 15 are software-generated and interrupts 16 to 31 are peripheral. For each interrupt it stores a group bit, a group-modifier bit, enable, pending and active flags, an 8-bit priority and a trigger type. Each software-generated interrupt also has a 2-bit non-secure access level. Software reaches this state through one register port. Every access carries a byte-lane size and a flag that says whether the access is secure.

Requests enter on a valid/ready channel. Every accepted request returns exactly one response beat on a second valid/ready channel, one cycle after it is accepted. A new request is taken only when no response is waiting, or when the waiting response is being taken in the same cycle. While `rsp_ready` is low, the response holds its value and `req_ready` stays low.

A global `sec_disable` input selects the security model. With security enabled, a non-secure access sees a banked view. Fields of interrupts that do not resolve to non-secure Group 1 read as zero and ignore writes, and priority values are seen in a shifted form. Arbitration and delivery of interrupts are handled elsewhere.

Top module: `irq_cfg_bank`

## Requirements
- R1: After reset, the group, modifier, enable, pending, active, priority, access-level and peripheral trigger fields are all zero. No response is pending.
- R2: `req_ready` is high when `rsp_valid` is low or `rsp_ready` is high. `rsp_valid` rises in the cycle after a request is accepted. While `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` hold.
- R3: With security disabled, a group bit of 0 resolves to Group 0 and a group bit of 1 resolves to non-secure Group 1, and a non-secure access sees every interrupt. With security enabled, the {modifier, group} pair resolves as follows: 00 is secure Group 0, 01 is non-secure Group 1, 10 is secure Group 1, and 11 is treated as non-secure Group 1.
- R4: Set and clear registers come in pairs: enable at 0x04 (set) and 0x08 (clear), pending at 0x0C and 0x10, active at 0x14 and 0x18. Bit i stands for interrupt i. Writing 1 to a set register sets that flag, writing 1 to a clear register clears it, and writing 0 has no effect. A read of either register in a pair returns the current flags.
- R5: When security is enabled and the access is non-secure, every per-interrupt field of an interrupt whose resolved group is not non-secure Group 1 reads as zero and ignores writes.
- R6: When security is enabled and the access is non-secure, a priority read returns the stored value shifted left by one and cut to 8 bits. A priority write stores 0x80 OR (written byte shifted right by one).
- R7: Priorities occupy the byte window 0x100 to 0x11F, one byte per interrupt. The first interrupt touched equals the byte offset into the window, and byte lane k of the access maps to interrupt offset+k.
- R8: Trigger registers use 2 bits per interrupt, and bit 2i+1 set means edge-triggered. The software-generated register at 0x1C always reports edge and ignores writes. The peripheral register at 0x20 stores bit 2i+1 for interrupt 16+i. Even bits read as zero.
- R9: The group register at 0x00 reads as zero and ignores writes for a non-secure access while security is enabled.
- R10: The modifier register at 0x24 and the access-level register at 0x28 read as zero and ignore writes when security is disabled or when the access is non-secure. Access levels are 2 bits each, packed at bit 2i for software-generated interrupt i.
- R11: `req_size` code 0 selects one byte lane, code 1 selects two lanes, and codes 2 and 3 select four lanes. Lanes outside the selected size ignore write data and read as zero.
- R12: An access to an offset outside the map returns `rsp_err` = 1 with zero data, changes no state, and raises the flag only on that response beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_disable | input | 1 | Global security-disable setting |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_size | input | 2 | Byte-lane size code |
| req_secure | input | 1 | Access is secure |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err | output | 1 | Unmapped offset flag for this response |

## Verification
The hardest situation to reach is a non-secure access that meets a mix of resolved groups. Secure accesses must first program the group and modifier bits so that neighbouring interrupts resolve to three different groups, including the {1,1} pair. Only then do non-secure reads and writes show the masking pattern and the shifted priority form. The stimulus also changes `sec_disable` between accesses to show that the modifier and access-level registers hide their contents and later expose them again unchanged. Back-pressure is forced by holding `rsp_ready` low for several cycles during a read.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

  localparam int unsigned PRIO_W = 8;

  localparam int unsigned OFS_GROUP    = 'h000;
  localparam int unsigned OFS_EN_SET   = 'h004;
  localparam int unsigned OFS_EN_CLR   = 'h008;
  localparam int unsigned OFS_PEND_SET = 'h00C;
  localparam int unsigned OFS_PEND_CLR = 'h010;
  localparam int unsigned OFS_ACT_SET  = 'h014;
  localparam int unsigned OFS_ACT_CLR  = 'h018;
  localparam int unsigned OFS_CFG_SW   = 'h01C;
  localparam int unsigned OFS_CFG_PER  = 'h020;
  localparam int unsigned OFS_GRPMOD   = 'h024;
  localparam int unsigned OFS_NSACC    = 'h028;
  localparam int unsigned OFS_PRIO     = 'h100;

  typedef enum logic [1:0] {
    GRP_SEC0  = 2'd0,
    GRP_NSEC1 = 2'd1,
    GRP_SEC1  = 2'd2
  } irq_grp_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_GROUP, SEL_EN_SET, SEL_EN_CLR, SEL_PEND_SET, SEL_PEND_CLR,
    SEL_ACT_SET, SEL_ACT_CLR, SEL_CFG_SW, SEL_CFG_PER, SEL_GRPMOD, SEL_NSACC,
    SEL_PRIO
  } reg_sel_e;

  function automatic irq_grp_e resolve_grp(input logic sec_off, input logic grp,
                                           input logic modf);
    if (sec_off) return grp ? GRP_NSEC1 : GRP_SEC0;
    case ({modf, grp})
      2'b00:   return GRP_SEC0;
      2'b10:   return GRP_SEC1;
      default: return GRP_NSEC1;
    endcase
  endfunction

endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
  import irqbank_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_IRQ = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [ADDR_W-1:0] prio_ofs
);
  localparam logic [ADDR_W-1:0] PRIO_LO = ADDR_W'(OFS_PRIO);
  localparam logic [ADDR_W-1:0] PRIO_HI = ADDR_W'(OFS_PRIO + NUM_IRQ);

  assign prio_ofs = addr - PRIO_LO;

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_GROUP))         sel = SEL_GROUP;
    else if (addr == ADDR_W'(OFS_EN_SET))   sel = SEL_EN_SET;
    else if (addr == ADDR_W'(OFS_EN_CLR))   sel = SEL_EN_CLR;
    else if (addr == ADDR_W'(OFS_PEND_SET)) sel = SEL_PEND_SET;
    else if (addr == ADDR_W'(OFS_PEND_CLR)) sel = SEL_PEND_CLR;
    else if (addr == ADDR_W'(OFS_ACT_SET))  sel = SEL_ACT_SET;
    else if (addr == ADDR_W'(OFS_ACT_CLR))  sel = SEL_ACT_CLR;
    else if (addr == ADDR_W'(OFS_CFG_SW))   sel = SEL_CFG_SW;
    else if (addr == ADDR_W'(OFS_CFG_PER))  sel = SEL_CFG_PER;
    else if (addr == ADDR_W'(OFS_GRPMOD))   sel = SEL_GRPMOD;
    else if (addr == ADDR_W'(OFS_NSACC))    sel = SEL_NSACC;
    else if (addr >= PRIO_LO && addr < PRIO_HI) sel = SEL_PRIO;
  end
endmodule

// File: rtl/irqbank_visibility.sv
module irqbank_visibility
  import irqbank_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               sec_off,
  input  logic               acc_secure,
  input  logic [NUM_IRQ-1:0] grp,
  input  logic [NUM_IRQ-1:0] modf,
  output logic [NUM_IRQ-1:0] vis
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    irq_grp_e res;
    assign res    = resolve_grp(sec_off, grp[i], modf[i]);
    assign vis[i] = sec_off | acc_secure | (res == GRP_NSEC1);
  end
endmodule

// File: rtl/irqbank_flagset.sv
module irqbank_flagset #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [N-1:0] hit,
  output logic [N-1:0] q
);
  logic [N-1:0] set_m, clr_m;
  assign set_m = set_we ? hit : '0;
  assign clr_m = clr_we ? hit : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irqbank_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_disable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_secure,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI;
  localparam int IDW     = $clog2(NUM_IRQ);
  localparam int NBYTES  = DATA_W / 8;

  reg_sel_e           sel;
  logic [ADDR_W-1:0]  prio_ofs;
  logic               acc, wr, ns_view, mod_ok;
  logic [2:0]         nbytes;
  logic [NBYTES-1:0]  lane_en;
  logic [DATA_W-1:0]  lane_bits;
  logic [NUM_IRQ-1:0] vis, wbits;
  logic [NUM_IRQ-1:0] grp_q, mod_q, en_q, pend_q, act_q;
  logic [NUM_PPI-1:0] edge_q;
  logic [1:0]         nsacc_q [NUM_SGI];
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic [DATA_W-1:0]  prio_rd, rd;

  assign req_ready = ~rsp_valid | rsp_ready;
  assign acc       = req_valid & req_ready;
  assign wr        = acc & req_write;
  assign ns_view   = ~sec_disable & ~req_secure;
  assign mod_ok    = ~sec_disable & req_secure;
  assign nbytes    = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_en[b]          = (3'(b) < nbytes);
    assign lane_bits[8*b +: 8] = {8{lane_en[b]}};
  end

  irqbank_decode #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_decode (
    .addr(req_addr), .sel(sel), .prio_ofs(prio_ofs)
  );

  irqbank_visibility #(.NUM_IRQ(NUM_IRQ)) u_vis (
    .sec_off(sec_disable), .acc_secure(req_secure),
    .grp(grp_q), .modf(mod_q), .vis(vis)
  );

  assign wbits = req_wdata[NUM_IRQ-1:0] & lane_bits[NUM_IRQ-1:0] & vis;

  irqbank_flagset #(.N(NUM_IRQ)) u_enable (
    .clk(clk), .rst_n(rst_n), .set_we(wr && sel == SEL_EN_SET),
    .clr_we(wr && sel == SEL_EN_CLR), .hit(wbits), .q(en_q)
  );
  irqbank_flagset #(.N(NUM_IRQ)) u_pending (
    .clk(clk), .rst_n(rst_n), .set_we(wr && sel == SEL_PEND_SET),
    .clr_we(wr && sel == SEL_PEND_CLR), .hit(wbits), .q(pend_q)
  );
  irqbank_flagset #(.N(NUM_IRQ)) u_active (
    .clk(clk), .rst_n(rst_n), .set_we(wr && sel == SEL_ACT_SET),
    .clr_we(wr && sel == SEL_ACT_CLR), .hit(wbits), .q(act_q)
  );

  // group and modifier words: whole-register filtering
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q <= '0;
      mod_q <= '0;
    end else begin
      if (wr && sel == SEL_GROUP && !ns_view)
        grp_q <= (grp_q & ~lane_bits[NUM_IRQ-1:0]) |
                 (req_wdata[NUM_IRQ-1:0] & lane_bits[NUM_IRQ-1:0]);
      if (wr && sel == SEL_GRPMOD && mod_ok)
        mod_q <= (mod_q & ~lane_bits[NUM_IRQ-1:0]) |
                 (req_wdata[NUM_IRQ-1:0] & lane_bits[NUM_IRQ-1:0]);
    end
  end

  // peripheral trigger type and access levels
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      for (int j = 0; j < NUM_SGI; j++) nsacc_q[j] <= 2'd0;
    end else begin
      for (int j = 0; j < NUM_PPI; j++)
        if (wr && sel == SEL_CFG_PER && lane_bits[2*j+1] && vis[NUM_SGI+j])
          edge_q[j] <= req_wdata[2*j+1];
      for (int j = 0; j < NUM_SGI; j++)
        if (wr && sel == SEL_NSACC && mod_ok && lane_bits[2*j])
          nsacc_q[j] <= req_wdata[2*j +: 2];
    end
  end

  // one priority register per interrupt; each picks its byte lane
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    logic [ADDR_W-1:0] rel;
    logic              hit;
    logic [PRIO_W-1:0] wbyte, val_q;
    assign rel   = ADDR_W'(i) - prio_ofs;
    assign hit   = (sel == SEL_PRIO) && (rel < ADDR_W'(nbytes)) && vis[i];
    assign wbyte = req_wdata[8*rel[1:0] +: 8];
    always_ff @(posedge clk) begin
      if (!rst_n)        val_q <= '0;
      else if (wr && hit) val_q <= ns_view ? (8'h80 | (wbyte >> 1)) : wbyte;
    end
    assign prio_flat[PRIO_W*i +: PRIO_W] = val_q;
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_prd
    logic [ADDR_W-1:0] pid;
    logic [PRIO_W-1:0] pv;
    assign pid = prio_ofs + ADDR_W'(b);
    assign pv  = prio_flat[PRIO_W*pid[IDW-1:0] +: PRIO_W];
    always_comb begin
      prio_rd[8*b +: 8] = '0;
      if (lane_en[b] && pid < ADDR_W'(NUM_IRQ) && vis[pid[IDW-1:0]])
        prio_rd[8*b +: 8] = ns_view ? {pv[PRIO_W-2:0], 1'b0} : pv;
    end
  end

  always_comb begin
    rd = '0;
    case (sel)
      SEL_GROUP:                rd = ns_view ? '0 : DATA_W'(grp_q);
      SEL_EN_SET, SEL_EN_CLR:   rd = DATA_W'(en_q & vis);
      SEL_PEND_SET, SEL_PEND_CLR: rd = DATA_W'(pend_q & vis);
      SEL_ACT_SET, SEL_ACT_CLR: rd = DATA_W'(act_q & vis);
      SEL_CFG_SW:  for (int j = 0; j < NUM_SGI; j++) rd[2*j+1] = vis[j];
      SEL_CFG_PER: for (int j = 0; j < NUM_PPI; j++) rd[2*j+1] = edge_q[j] & vis[NUM_SGI+j];
      SEL_GRPMOD:  rd = mod_ok ? DATA_W'(mod_q) : '0;
      SEL_NSACC:   if (mod_ok) for (int j = 0; j < NUM_SGI; j++) rd[2*j +: 2] = nsacc_q[j];
      SEL_PRIO:    rd = prio_rd;
      default:     rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : (rd & lane_bits);
      rsp_err   <= (sel == SEL_NONE);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_bank_checker.sv
module irq_cfg_bank_checker
  import irqbank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_disable,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_secure,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err
);
  logic ns_rd;
  assign ns_rd = req_valid && req_ready && !req_write && !req_secure && !sec_disable;

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R2
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R2
  AST_ERR_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R12
  AST_NS_GROUP_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    ns_rd && req_addr == ADDR_W'(OFS_GROUP) |=> rsp_rdata == '0); // R9
  AST_NS_MOD_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && (sec_disable || !req_secure) &&
    (req_addr == ADDR_W'(OFS_GRPMOD) || req_addr == ADDR_W'(OFS_NSACC))
    |=> rsp_rdata == '0); // R10
  AST_NS_PRIO_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
    ns_rd && req_addr >= ADDR_W'(OFS_PRIO) |=> (rsp_rdata & 32'h0101_0101) == '0); // R6
  AST_CFG_EVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write &&
    (req_addr == ADDR_W'(OFS_CFG_SW) || req_addr == ADDR_W'(OFS_CFG_PER))
    |=> (rsp_rdata & 32'h5555_5555) == '0); // R8
endmodule

bind irq_cfg_bank irq_cfg_bank_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
);

// File: tb/irq_cfg_bank_bench.sv
module irq_cfg_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_disable = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic        req_secure = 1'b1;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd_v;
  logic        er_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cfg_bank u_irq_cfg_bank (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_secure(req_secure),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [11:0] a, input logic [1:0] sz,
                        input bit sec, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz;
    req_secure = sec; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rd_v = rsp_rdata; er_v = rsp_err;
    if (!rsp_valid) begin
      checks++; errors++;
      $display("FAIL R2: actual rsp_valid 0 expected 1");
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz, input bit sec);
    access(1'b0, a, sz, sec, '0);
  endtask

  task automatic wrt(input logic [11:0] a, input logic [1:0] sz, input bit sec, input logic [31:0] d);
    access(1'b1, a, sz, sec, d);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rd(12'h000, 2, 1); chk("R1 group", rd_v, 0);
    rd(12'h004, 2, 1); chk("R1 enable", rd_v, 0);
    rd(12'h100, 2, 1); chk("R1 prio", rd_v, 0);
    rd(12'h01C, 2, 1); chk("R8 sgi edge", rd_v, 32'hAAAA_AAAA);
    rd(12'h020, 2, 1); chk("R1 ppi cfg", rd_v, 0);
    chk("R12 no err", {31'd0, er_v}, 0);
  endtask

  task automatic t_setclr;
    wrt(12'h004, 2, 1, 32'h0000_0105);
    rd(12'h008, 2, 1); chk("R4 enable set", rd_v, 32'h105);
    wrt(12'h008, 2, 1, 32'h0000_0004);
    wrt(12'h004, 2, 1, 32'h0);
    rd(12'h004, 2, 1); chk("R4 enable clear", rd_v, 32'h101);
    wrt(12'h014, 2, 1, 32'h8000_0001);
    wrt(12'h018, 2, 1, 32'h8000_0000);
    rd(12'h014, 2, 1); chk("R4 active", rd_v, 32'h1);
    wrt(12'h008, 2, 1, 32'hFFFF_FFFF);
    wrt(12'h018, 2, 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_size;
    wrt(12'h00C, 0, 1, 32'hFFFF_FFFF);
    rd(12'h00C, 2, 1); chk("R11 byte write", rd_v, 32'hFF);
    wrt(12'h010, 1, 1, 32'hFFFF_FF01);
    rd(12'h010, 2, 1); chk("R4 pend clear", rd_v, 32'hFE);
    wrt(12'h00C, 2, 1, 32'h0001_0000);
    rd(12'h00C, 0, 1); chk("R11 byte read", rd_v, 32'hFE);
    wrt(12'h010, 2, 1, 32'hFFFF_FFFF);
  endtask

  task automatic t_prio;
    wrt(12'h100, 2, 1, 32'h4433_2211);
    rd(12'h102, 0, 1); chk("R7 byte 2", rd_v, 32'h33);
    rd(12'h101, 1, 1); chk("R7 half at 1", rd_v, 32'h3322);
    rd(12'h11F, 2, 1); chk("R7 last lane", rd_v, 0);
  endtask

  task automatic t_groups;
    wrt(12'h000, 2, 1, 32'h0000_000A);
    wrt(12'h024, 2, 1, 32'h0000_000C);
    wrt(12'h004, 2, 1, 32'h0000_000F);
    rd(12'h004, 2, 0); chk("R5 ns enable view", rd_v, 32'hA);
    wrt(12'h008, 2, 0, 32'h0000_000F);
    rd(12'h004, 2, 1); chk("R3 ns clear filtered", rd_v, 32'h5);
    rd(12'h000, 2, 0); chk("R9 ns group read", rd_v, 0);
    wrt(12'h000, 2, 0, 32'hFFFF_FFFF);
    rd(12'h000, 2, 1); chk("R9 ns group write", rd_v, 32'hA);
    rd(12'h024, 2, 0); chk("R10 ns modifier read", rd_v, 0);
    wrt(12'h024, 2, 0, 32'h0);
    rd(12'h024, 2, 1); chk("R10 ns modifier write", rd_v, 32'hC);
    rd(12'h01C, 2, 0); chk("R5 ns sgi cfg", rd_v, 32'h88);
  endtask

  task automatic t_ns_prio;
    wrt(12'h101, 0, 1, 32'h40);
    rd(12'h101, 0, 0); chk("R6 ns read", rd_v, 32'h80);
    wrt(12'h101, 0, 0, 32'h20);
    rd(12'h101, 0, 1); chk("R6 ns write stored", rd_v, 32'h90);
    rd(12'h100, 1, 0); chk("R5 ns prio mix", rd_v, 32'h2000);
    wrt(12'h100, 0, 0, 32'h55);
    rd(12'h100, 0, 1); chk("R5 ns prio ignored", rd_v, 32'h11);
  endtask

  task automatic t_cfg;
    wrt(12'h020, 2, 1, 32'h8000_0003);
    rd(12'h020, 2, 1); chk("R8 ppi cfg", rd_v, 32'h8000_0002);
    wrt(12'h01C, 2, 1, 32'h0);
    rd(12'h01C, 2, 1); chk("R8 sgi fixed", rd_v, 32'hAAAA_AAAA);
  endtask

  task automatic t_nsacc;
    wrt(12'h028, 2, 1, 32'h0000_00E4);
    rd(12'h028, 2, 1); chk("R10 access level", rd_v, 32'hE4);
    sec_disable = 1'b1;
    rd(12'h028, 2, 1); chk("R10 hidden when disabled", rd_v, 0);
    wrt(12'h028, 2, 1, 32'h0);
    rd(12'h004, 2, 0); chk("R3 disabled ns sees all", rd_v, 32'h5);
    sec_disable = 1'b0;
    rd(12'h028, 2, 1); chk("R10 kept", rd_v, 32'hE4);
  endtask

  task automatic t_unmapped;
    rd(12'h040, 2, 1);
    chk("R12 err", {31'd0, er_v}, 1); chk("R12 data", rd_v, 0);
    wrt(12'h02C, 2, 1, 32'hFFFF_FFFF);
    chk("R12 write err", {31'd0, er_v}, 1);
    rd(12'h120, 0, 1); chk("R12 past window", {31'd0, er_v}, 1);
    rd(12'h004, 2, 1);
    chk("R12 err cleared", {31'd0, er_v}, 0); chk("R12 no state change", rd_v, 32'h5);
  endtask

  task automatic t_backpressure;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h004; req_size = 2; req_secure = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 valid", {31'd0, rsp_valid}, 1);
    chk("R2 ready low", {31'd0, req_ready}, 0);
    @(negedge clk);
    chk("R2 held valid", {31'd0, rsp_valid}, 1);
    chk("R2 held data", rsp_rdata, 32'h5);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R2 drained", {31'd0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setclr();
    t_size();
    t_prio();
    t_groups();
    t_ns_prio();
    t_cfg();
    t_nsacc();
    t_unmapped();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule